// File: doc/BRIEF.md
# Set Replacement Victim Selector

This block picks the way to evict from one set of an N-way set-associative cache. The cache controller sends it a strobe and a way index on every hit or fill to that set. It also drives the set's valid bits. When a new block must be placed, the controller reads `victim_o` and raises `repl_req_i` to show that the placement happens in that cycle.

A two-bit mode input chooses the policy while the block runs. The policies are true least-recently-used, pseudo-random and round-robin. All three state machines keep running in every mode, so a switch of policy takes effect on the next lookup. If any way in the set is invalid, that way is used ahead of every policy.

Top module: `way_victim_sel`

## Requirements
- R1: After reset the recency order runs from way 0 (most recent) to way N-1 (least recent), so the LRU victim is N-1. The round-robin pointer is 0, and the random generator holds its seed 0xACE1.
- R2: When the valid bits are not all ones, `victim_o` is the lowest-numbered invalid way, whatever the mode.
- R3: In LRU mode with a full set, `victim_o` is the way whose most recent hit or fill is the oldest.
- R4: A `touch_i` strobe makes `touch_way_i` the most recent way. The ways that were more recent than it each move one place older. The ways that were older keep their places. The update happens in every mode.
- R5: In random mode with a full set, `victim_o` equals the low log2(N) bits of a 16-bit right-shifting Galois LFSR. The LFSR has feedback mask 0xB400, is loaded with 0xACE1 in reset and steps on every clock after reset. Touches do not affect it.
- R6: In round-robin mode with a full set, `victim_o` is the pointer. When `repl_req_i` is high on a clock edge, the pointer steps by one modulo N, wrapping from N-1 to 0.
- R7: The pointer holds on hits and fills. It also holds on a request made while the set has an invalid way or while the block is not in round-robin mode.
- R8: The mode encoding is 0 = LRU, 1 = random, 2 = round-robin. Code 3 behaves as LRU.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Policy select (R8 encoding) |
| touch_i | input | 1 | Hit or fill strobe for the set |
| touch_way_i | input | log2(WAYS) | Way that was hit or filled |
| valid_i | input | WAYS | Valid bit of each way in the set |
| repl_req_i | input | 1 | A replacement takes place this cycle |
| victim_o | output | log2(WAYS) | Way chosen for eviction |

## Verification
For LRU, the bench touches ways in several orders: the current least-recent way, a middle way, a way that is already most recent, and way 0. These cases tell a real move-to-front update apart from a plain swap or a partial shift. For round-robin, it mixes replacements with hits, with a request made while the set is partly empty, and with a request made in LRU mode, so that an unwanted step of the pointer shows up. Valid patterns with holes at the low and the high end check that the lowest invalid way wins over every policy. A long run in random mode, with touches interleaved, is compared each cycle against an independent model of the generator.

// File: rtl/victim_pkg.sv
package victim_pkg;
   typedef enum logic [1:0] {
      POL_LRU  = 2'd0,
      POL_RAND = 2'd1,
      POL_RR   = 2'd2,
      POL_ALT  = 2'd3
   } policy_e;
endpackage

// File: rtl/lru_order.sv
module lru_order #(
   parameter int WAYS = 4,
   localparam int WW = $clog2(WAYS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          touch_i,
   input  logic [WW-1:0] touch_way_i,
   output logic [WW-1:0] oldest_o
);
   // rank[0] is most recent, rank[WAYS-1] least recent
   logic [WW-1:0] rank   [WAYS];
   logic [WW-1:0] rank_n [WAYS];
   logic [WW-1:0] hit_pos;

   always_comb begin
      hit_pos = '0;
      for (int i = 0; i < WAYS; i++)
         if (rank[i] == touch_way_i) hit_pos = WW'(i);
   end

   always_comb begin
      rank_n[0] = touch_way_i;
      for (int i = 1; i < WAYS; i++)
         rank_n[i] = (WW'(i) <= hit_pos) ? rank[i-1] : rank[i];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < WAYS; i++) rank[i] <= WW'(i);
      end else if (touch_i) begin
         for (int i = 0; i < WAYS; i++) rank[i] <= rank_n[i];
      end
   end

   assign oldest_o = rank[WAYS-1];
endmodule

// File: rtl/lfsr_gen.sv
module lfsr_gen #(
   parameter int LFSR_W = 16,
   parameter logic [LFSR_W-1:0] SEED = 16'hACE1
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic [LFSR_W-1:0] state_o
);
   logic [LFSR_W-1:0] taps;

   generate
      if (LFSR_W == 16) begin : g_w16
         assign taps = 16'hB400;
      end else if (LFSR_W == 8) begin : g_w8
         assign taps = 8'hB8;
      end else begin : g_bad
         $error("lfsr_gen: LFSR_W must be 8 or 16");
         assign taps = '0;
      end
      if (SEED == '0) begin : g_seed_bad
         $error("lfsr_gen: SEED must be non-zero");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_o <= SEED;
      else        state_o <= (state_o >> 1) ^ (state_o[0] ? taps : '0);
   end
endmodule

// File: rtl/rr_pointer.sv
module rr_pointer #(
   parameter int WAYS = 4,
   localparam int WW = $clog2(WAYS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          step_i,
   output logic [WW-1:0] ptr_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ptr_o <= '0;
      else if (step_i) ptr_o <= ptr_o + 1'b1;
   end
endmodule

// File: rtl/way_victim_sel.sv
module way_victim_sel
   import victim_pkg::*;
#(
   parameter int WAYS = 4,
   parameter int LFSR_W = 16,
   parameter logic [LFSR_W-1:0] SEED = 16'hACE1,
   localparam int WW = $clog2(WAYS)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [1:0]      mode_i,
   input  logic            touch_i,
   input  logic [WW-1:0]   touch_way_i,
   input  logic [WAYS-1:0] valid_i,
   input  logic            repl_req_i,
   output logic [WW-1:0]   victim_o
);
   generate
      if (WAYS < 2 || (WAYS & (WAYS - 1)) != 0) begin : g_ways_bad
         $error("way_victim_sel: WAYS must be a power of two >= 2");
      end
      if (LFSR_W < WW) begin : g_lfsr_bad
         $error("way_victim_sel: LFSR_W narrower than way index");
      end
   endgenerate

   policy_e       pol;
   logic          set_full;
   logic [WW-1:0] free_way;
   logic [WW-1:0] lru_way;
   logic [WW-1:0] rr_way;
   logic [LFSR_W-1:0] rnd;
   logic          rr_step;

   assign pol      = policy_e'(mode_i);
   assign set_full = &valid_i;
   assign rr_step  = repl_req_i && set_full && (pol == POL_RR);

   always_comb begin
      free_way = '0;
      for (int i = WAYS - 1; i >= 0; i--)
         if (!valid_i[i]) free_way = WW'(i);
   end

   lru_order #(.WAYS(WAYS)) u_lru (
      .clk(clk), .rst_n(rst_n), .touch_i(touch_i),
      .touch_way_i(touch_way_i), .oldest_o(lru_way)
   );

   rr_pointer #(.WAYS(WAYS)) u_rr (
      .clk(clk), .rst_n(rst_n), .step_i(rr_step), .ptr_o(rr_way)
   );

   lfsr_gen #(.LFSR_W(LFSR_W), .SEED(SEED)) u_rng (
      .clk(clk), .rst_n(rst_n), .state_o(rnd)
   );

   always_comb begin
      if (!set_full) victim_o = free_way;
      else begin
         case (pol)
            POL_RAND: victim_o = rnd[WW-1:0];
            POL_RR:   victim_o = rr_way;
            default:  victim_o = lru_way;
         endcase
      end
   end
endmodule

// File: rtl/way_victim_sel_chk.sv
module way_victim_sel_chk #(
   parameter int WAYS = 4,
   localparam int WW = $clog2(WAYS)
) (
   input logic            clk,
   input logic            rst_n,
   input logic [1:0]      mode_i,
   input logic            touch_i,
   input logic [WW-1:0]   touch_way_i,
   input logic [WAYS-1:0] valid_i,
   input logic            repl_req_i,
   input logic [WW-1:0]   victim_o
);
   logic full, in_rr, in_lru;
   assign full   = &valid_i;
   assign in_rr  = (mode_i == 2'd2);
   assign in_lru = (mode_i == 2'd0) || (mode_i == 2'd3);

   // R2
   free_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !full |-> !valid_i[victim_o]);

   // R6
   rr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_rr && full && repl_req_i) |=>
      (!(in_rr && full) || victim_o == WW'($past(victim_o) + 1'b1)));

   // R7
   rr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_rr && full && !repl_req_i) |=>
      (!(in_rr && full) || $stable(victim_o)));

   // R4
   lru_fresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
      touch_i |=> (!(in_lru && full) || victim_o != $past(touch_way_i)));
endmodule

bind way_victim_sel way_victim_sel_chk #(.WAYS(WAYS)) u_chk (
   .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .touch_i(touch_i),
   .touch_way_i(touch_way_i), .valid_i(valid_i),
   .repl_req_i(repl_req_i), .victim_o(victim_o)
);

// File: tb/way_victim_sel_tb_top.sv
module way_victim_sel_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] mode_i = 2'd0;
   logic       touch_i = 1'b0;
   logic [1:0] touch_way_i = 2'd0;
   logic [3:0] valid_i = 4'hF;
   logic       repl_req_i = 1'b0;
   logic [1:0] victim_o;

   int n_chk = 0;
   int n_bad = 0;
   logic [15:0] mdl;

   always #10 clk = ~clk;

   way_victim_sel dut_i (
      .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .touch_i(touch_i),
      .touch_way_i(touch_way_i), .valid_i(valid_i),
      .repl_req_i(repl_req_i), .victim_o(victim_o)
   );

   // generator model taken from R5
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mdl <= 16'hACE1;
      else        mdl <= (mdl >> 1) ^ (mdl[0] ? 16'hB400 : 16'h0000);
   end

   typedef struct packed {
      logic [3:0] req;
      logic [1:0] mode;
      logic       touch;
      logic [1:0] tway;
      logic [3:0] valid;
      logic       repl;
      logic [1:0] exp;
   } vec_t;

   localparam int NV = 22;
   localparam vec_t VEC [NV] = '{
      '{4'd1, 2'd0, 1'b0, 2'd0, 4'hF, 1'b0, 2'd3},
      '{4'd3, 2'd0, 1'b1, 2'd3, 4'hF, 1'b0, 2'd3},
      '{4'd4, 2'd0, 1'b0, 2'd0, 4'hF, 1'b0, 2'd2},
      '{4'd4, 2'd0, 1'b1, 2'd1, 4'hF, 1'b0, 2'd2},
      '{4'd4, 2'd0, 1'b1, 2'd2, 4'hF, 1'b0, 2'd2},
      '{4'd3, 2'd0, 1'b0, 2'd0, 4'hF, 1'b0, 2'd0},
      '{4'd4, 2'd0, 1'b1, 2'd2, 4'hF, 1'b0, 2'd0},
      '{4'd4, 2'd0, 1'b0, 2'd0, 4'hF, 1'b0, 2'd0},
      '{4'd4, 2'd0, 1'b1, 2'd0, 4'hF, 1'b0, 2'd0},
      '{4'd3, 2'd0, 1'b0, 2'd0, 4'hF, 1'b0, 2'd3},
      '{4'd2, 2'd0, 1'b0, 2'd0, 4'b1011, 1'b0, 2'd2},
      '{4'd2, 2'd0, 1'b0, 2'd0, 4'b0110, 1'b0, 2'd0},
      '{4'd6, 2'd2, 1'b0, 2'd0, 4'hF, 1'b1, 2'd0},
      '{4'd7, 2'd2, 1'b1, 2'd0, 4'hF, 1'b0, 2'd1},
      '{4'd6, 2'd2, 1'b0, 2'd0, 4'hF, 1'b1, 2'd1},
      '{4'd2, 2'd2, 1'b0, 2'd0, 4'b0111, 1'b1, 2'd3},
      '{4'd7, 2'd2, 1'b0, 2'd0, 4'hF, 1'b1, 2'd2},
      '{4'd6, 2'd2, 1'b0, 2'd0, 4'hF, 1'b1, 2'd3},
      '{4'd6, 2'd2, 1'b0, 2'd0, 4'hF, 1'b0, 2'd0},
      '{4'd3, 2'd0, 1'b0, 2'd0, 4'hF, 1'b1, 2'd3},
      '{4'd7, 2'd2, 1'b0, 2'd0, 4'hF, 1'b0, 2'd0},
      '{4'd8, 2'd3, 1'b0, 2'd0, 4'hF, 1'b0, 2'd3}
   };

   task automatic check(input string tag, input logic [1:0] act, input logic [1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: victim_o=%0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic string rtag(input logic [3:0] r);
      case (r)
         4'd1: return "R1";   4'd2: return "R2";   4'd3: return "R3";
         4'd4: return "R4";   4'd5: return "R5";   4'd6: return "R6";
         4'd7: return "R7";   default: return "R8";
      endcase
   endfunction

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state seen through the LRU and round-robin outputs
      #2 check("R1 lru", victim_o, 2'd3);
      mode_i = 2'd2;
      #1 check("R1 rr", victim_o, 2'd0);
      mode_i = 2'd1;
      #1 check("R1 rand seed", victim_o, mdl[1:0]);
      mode_i = 2'd0;

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         mode_i      = VEC[i].mode;
         touch_i     = VEC[i].touch;
         touch_way_i = VEC[i].tway;
         valid_i     = VEC[i].valid;
         repl_req_i  = VEC[i].repl;
         #2 check(rtag(VEC[i].req), victim_o, VEC[i].exp);
      end

      // R5: random victim follows the generator, touches ignored
      for (int k = 0; k < 40; k++) begin
         @(negedge clk);
         mode_i      = 2'd1;
         valid_i     = 4'hF;
         repl_req_i  = k[0];
         touch_i     = k[1];
         touch_way_i = k[3:2];
         #2 check("R5", victim_o, mdl[1:0]);
      end

      // R2: a hole in the set beats the random policy
      @(negedge clk);
      touch_i = 1'b0; repl_req_i = 1'b0; valid_i = 4'b0111;
      #2 check("R2 rand", victim_o, 2'd3);

      // R1: second reset restores the pointer and the order
      @(negedge clk);
      rst_n = 1'b0; valid_i = 4'hF; mode_i = 2'd2;
      @(negedge clk);
      rst_n = 1'b1;
      #2 check("R1 rr again", victim_o, 2'd0);
      mode_i = 2'd0;
      #1 check("R1 lru again", victim_o, 2'd3);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      #2000000;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not end, actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule